// File: doc/BRIEF.md
# Fetch Group Slicer

The block takes one instruction-cache line together with the PC that fetch starts from, and carves a group of up to `GROUP_W` consecutive 4-byte instructions out of that line for the decode stage. Every instruction it emits carries its own PC and a unique sequence number taken from a counter kept inside the block.

A branch predictor supplies, for every word position of the line, a predicted-taken flag and a predicted target. The group ends at the first of three events: the end of the line, the group-width limit, or an instruction predicted taken. A predicted-taken instruction still belongs to the group. The block reports the PC to fetch from next, which is either the predicted target or the fall-through address, and that PC plus 4.

All results are registered and appear one clock after the line is presented.

Top module: `fetch_group_slicer`

## Requirements
- R1: The first extracted word sits at line word index `(start_pc & (LINE_BYTES-1)) >> 2`. Slot k holds word index start+k, where word w is `line_data[32*w+31 : 32*w]`. This places the byte at the lowest line address in the least significant byte of the word (little-endian).
- R2: Extraction stops once the word index passes the last word of the line, or once `GROUP_W` instructions have been taken. `grp_size` never exceeds `GROUP_W`.
- R3: If the instruction at line word w has `pred_taken[w]` high, it is included and every later slot is invalid. `grp_vld` is always a run of ones from bit 0 whose length equals `grp_size`.
- R4: Valid slot k carries sequence number `seq_ctr_before + k`. After a group, `seq_ctr` has advanced by exactly `grp_size`.
- R5: Valid slot k carries PC `start_pc + 4*k`. `nxt_pc` is `pred_tgt[w]` of the last instruction when that instruction is predicted taken, and otherwise that instruction's PC plus 4.
- R6: `nxt_nxt_pc` always equals `nxt_pc + 4`.
- R7: All group outputs reflect the inputs sampled at the previous rising clock edge.
- R8: A cycle with `line_vld` low consumes no sequence numbers and leaves all slot valids and `grp_size` zero. It also leaves `nxt_pc` and `nxt_nxt_pc` unchanged.
- R9: After reset, the following hold: `grp_vld`, `grp_size`, `seq_ctr` and `nxt_pc` are zero, and `nxt_nxt_pc` is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_vld | input | 1 | A cache line and start PC are presented this cycle |
| line_data | input | LINE_BYTES*8 | Cache line contents, byte 0 in bits 7:0 |
| start_pc | input | ADDR_W | PC where extraction starts (word aligned) |
| pred_taken | input | LINE_BYTES/4 | Predicted-taken flag per line word |
| pred_tgt | input | (LINE_BYTES/4)*ADDR_W | Predicted target per line word, word w in bits ADDR_W*w upward |
| grp_vld | output | GROUP_W | Valid flag per output slot |
| grp_insn | output | GROUP_W*32 | Instruction word per slot |
| grp_pc | output | GROUP_W*ADDR_W | PC per slot |
| grp_seq | output | GROUP_W*SEQ_W | Sequence number per slot |
| grp_size | output | $clog2(GROUP_W+1) | Number of valid slots |
| nxt_pc | output | ADDR_W | PC to fetch next |
| nxt_nxt_pc | output | ADDR_W | nxt_pc plus 4 |
| seq_ctr | output | SEQ_W | Next unused sequence number |

## Verification
The bench drives lines that start at word 0 with no prediction, which shows the width limit, and lines that start near the line's end, which show the line boundary. Lines with a taken prediction at the first or second slot show that the group ends early and that the next PC is redirected. A taken flag placed beyond the width limit shows that a flag outside the group has no effect. Idle cycles between groups and a run of pseudo-random start PCs and flags confirm that sequence numbering carries across groups and that idle cycles hold the next PC.

// File: rtl/fetch_group_slicer.sv
module fetch_group_slicer #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int GROUP_W    = 4,
  parameter int SEQ_W      = 16,
  localparam int WORDS     = LINE_BYTES / 4,
  localparam int CNT_W     = $clog2(GROUP_W + 1),
  localparam int WIDX_W    = $clog2(WORDS),
  localparam int OFF_W     = $clog2(LINE_BYTES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      line_vld,
  input  logic [LINE_BYTES*8-1:0]   line_data,
  input  logic [ADDR_W-1:0]         start_pc,
  input  logic [WORDS-1:0]          pred_taken,
  input  logic [WORDS*ADDR_W-1:0]   pred_tgt,
  output logic [GROUP_W-1:0]        grp_vld,
  output logic [GROUP_W*32-1:0]     grp_insn,
  output logic [GROUP_W*ADDR_W-1:0] grp_pc,
  output logic [GROUP_W*SEQ_W-1:0]  grp_seq,
  output logic [CNT_W-1:0]          grp_size,
  output logic [ADDR_W-1:0]         nxt_pc,
  output logic [ADDR_W-1:0]         nxt_nxt_pc,
  output logic [SEQ_W-1:0]          seq_ctr
);

  logic [GROUP_W-1:0]        vld_c;
  logic [GROUP_W*32-1:0]     insn_c;
  logic [GROUP_W*ADDR_W-1:0] pc_c;
  logic [GROUP_W*SEQ_W-1:0]  seq_c;
  logic [CNT_W-1:0]          cnt_c;
  logic [ADDR_W-1:0]         npc_c;

  int                start_w;
  int                w;
  logic [WIDX_W-1:0] wi;
  logic              stop;
  logic [ADDR_W-1:0] pc_k;

  always_comb begin
    start_w = int'(start_pc[OFF_W-1:2]);
    stop    = 1'b0;
    cnt_c   = '0;
    npc_c   = start_pc;
    vld_c   = '0;
    insn_c  = '0;
    pc_c    = '0;
    seq_c   = '0;
    w       = 0;
    wi      = '0;
    pc_k    = '0;
    for (int k = 0; k < GROUP_W; k++) begin
      w    = start_w + k;
      wi   = w[WIDX_W-1:0];
      pc_k = start_pc + ADDR_W'(4 * k);
      if (line_vld && !stop && w < WORDS) begin
        vld_c[k]                  = 1'b1;
        insn_c[k*32 +: 32]        = line_data[32*wi +: 32];
        pc_c[k*ADDR_W +: ADDR_W]  = pc_k;
        seq_c[k*SEQ_W +: SEQ_W]   = seq_ctr + SEQ_W'(k);
        cnt_c                     = cnt_c + CNT_W'(1);
        if (pred_taken[wi]) begin
          npc_c = pred_tgt[ADDR_W*wi +: ADDR_W];
          stop  = 1'b1;
        end else begin
          npc_c = pc_k + ADDR_W'(4);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_vld    <= '0;
      grp_insn   <= '0;
      grp_pc     <= '0;
      grp_seq    <= '0;
      grp_size   <= '0;
      nxt_pc     <= '0;
      nxt_nxt_pc <= ADDR_W'(4);
      seq_ctr    <= '0;
    end else begin
      grp_vld  <= vld_c;
      grp_insn <= insn_c;
      grp_pc   <= pc_c;
      grp_seq  <= seq_c;
      grp_size <= cnt_c;
      seq_ctr  <= seq_ctr + SEQ_W'(cnt_c);
      if (line_vld) begin
        nxt_pc     <= npc_c;
        nxt_nxt_pc <= npc_c + ADDR_W'(4);
      end
    end
  end

endmodule

// File: rtl/fetch_group_slicer_chk.sv
module fetch_group_slicer_chk #(
  parameter int ADDR_W  = 32,
  parameter int GROUP_W = 4,
  parameter int SEQ_W   = 16,
  parameter int CNT_W   = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      line_vld,
  input logic [ADDR_W-1:0]         start_pc,
  input logic [GROUP_W-1:0]        grp_vld,
  input logic [GROUP_W*ADDR_W-1:0] grp_pc,
  input logic [GROUP_W*SEQ_W-1:0]  grp_seq,
  input logic [CNT_W-1:0]          grp_size,
  input logic [ADDR_W-1:0]         nxt_pc,
  input logic [ADDR_W-1:0]         nxt_nxt_pc,
  input logic [SEQ_W-1:0]          seq_ctr
);

  logic seen;
  always_ff @(posedge clk) seen <= rst_n;

  p_size_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(grp_size) <= GROUP_W);

  p_prefix_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (($countones(grp_vld) == 32'(grp_size)) && ((grp_vld & (grp_vld + 1'b1)) == '0)));

  p_seq_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> seq_ctr == $past(seq_ctr) + SEQ_W'(grp_size));

  p_first_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && grp_vld[0]) |-> grp_seq[SEQ_W-1:0] == $past(seq_ctr));

  p_first_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && grp_vld[0]) |-> grp_pc[ADDR_W-1:0] == $past(start_pc));

  p_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_nxt_pc == nxt_pc + ADDR_W'(4));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(line_vld)) |-> (grp_vld == '0 && $stable(seq_ctr) && $stable(nxt_pc)));

endmodule

bind fetch_group_slicer fetch_group_slicer_chk #(
  .ADDR_W(ADDR_W), .GROUP_W(GROUP_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/fetch_group_slicer_test.sv
module fetch_group_slicer_test;
  localparam int AW = 32, LB = 32, GW = 4, SW = 16, NW = LB / 4;

  logic           clk = 0;
  logic           rst_n = 0;
  logic           line_vld = 0;
  logic [LB*8-1:0] line_data = '0;
  logic [AW-1:0]  start_pc = '0;
  logic [NW-1:0]  pred_taken = '0;
  logic [NW*AW-1:0] pred_tgt = '0;
  logic [GW-1:0]  grp_vld;
  logic [GW*32-1:0] grp_insn;
  logic [GW*AW-1:0] grp_pc;
  logic [GW*SW-1:0] grp_seq;
  logic [2:0]     grp_size;
  logic [AW-1:0]  nxt_pc, nxt_nxt_pc;
  logic [SW-1:0]  seq_ctr;

  fetch_group_slicer #(.ADDR_W(AW), .LINE_BYTES(LB), .GROUP_W(GW), .SEQ_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .line_vld(line_vld), .line_data(line_data),
    .start_pc(start_pc), .pred_taken(pred_taken), .pred_tgt(pred_tgt),
    .grp_vld(grp_vld), .grp_insn(grp_insn), .grp_pc(grp_pc), .grp_seq(grp_seq),
    .grp_size(grp_size), .nxt_pc(nxt_pc), .nxt_nxt_pc(nxt_nxt_pc), .seq_ctr(seq_ctr));

  always #4 clk = ~clk;

  typedef struct {
    logic [GW-1:0] vld;
    logic [31:0]   insn [GW];
    logic [AW-1:0] pc   [GW];
    logic [SW-1:0] seq  [GW];
    int            size;
    logic [AW-1:0] npc;
    logic [SW-1:0] seq_after;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  logic [AW-1:0] m_npc = '0;
  logic [SW-1:0] m_seq = '0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [AW-1:0] pc, input logic [NW-1:0] tk, input int salt);
    exp_t e;
    logic [7:0] b [LB];
    logic [AW-1:0] tg [NW];
    int w0, n;
    logic done;
    @(negedge clk);
    for (int i = 0; i < LB; i++) b[i] = 8'(salt * 7 + i * 13 + 1);
    for (int i = 0; i < NW; i++) tg[i] = 32'h8000_0000 + AW'(salt * 256 + i * 16);
    e.vld = '0; e.size = 0;
    for (int k = 0; k < GW; k++) begin e.insn[k] = '0; e.pc[k] = '0; e.seq[k] = '0; end
    if (v) begin
      w0 = int'(pc[4:2]); n = 0; done = 0;
      while (!done && n < GW && w0 + n < NW) begin
        e.vld[n]  = 1'b1;
        e.insn[n] = {b[4*(w0+n)+3], b[4*(w0+n)+2], b[4*(w0+n)+1], b[4*(w0+n)]};
        e.pc[n]   = pc + AW'(4 * n);
        e.seq[n]  = m_seq + SW'(n);
        if (tk[w0+n]) begin m_npc = tg[w0+n]; done = 1; end
        else m_npc = pc + AW'(4 * n + 4);
        n++;
      end
      e.size = n;
      m_seq = m_seq + SW'(n);
    end
    e.npc = m_npc;
    e.seq_after = m_seq;
    q.push_back(e);
    line_vld = v;
    start_pc = pc;
    pred_taken = tk;
    for (int i = 0; i < LB; i++) line_data[8*i +: 8] = b[i];
    for (int i = 0; i < NW; i++) pred_tgt[AW*i +: AW] = tg[i];
  endtask

  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk("R3/R8", "grp_vld", 64'(grp_vld), 64'(e.vld));
        chk("R2", "grp_size", 64'(grp_size), 64'(e.size));
        for (int k = 0; k < GW; k++) if (e.vld[k]) begin
          chk("R1", "insn", 64'(grp_insn[32*k +: 32]), 64'(e.insn[k]));
          chk("R5", "pc", 64'(grp_pc[AW*k +: AW]), 64'(e.pc[k]));
          chk("R4", "seq", 64'(grp_seq[SW*k +: SW]), 64'(e.seq[k]));
        end
        chk("R5/R7", "nxt_pc", 64'(nxt_pc), 64'(e.npc));
        chk("R6", "nxt_nxt_pc", 64'(nxt_nxt_pc), 64'(e.npc + 4));
        chk("R4/R8", "seq_ctr", 64'(seq_ctr), 64'(e.seq_after));
      end
    end
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", "reset grp_vld", 64'(grp_vld), 0);
    chk("R9", "reset grp_size", 64'(grp_size), 0);
    chk("R9", "reset seq_ctr", 64'(seq_ctr), 0);
    chk("R9", "reset nxt_pc", 64'(nxt_pc), 0);
    chk("R9", "reset nxt_nxt_pc", 64'(nxt_nxt_pc), 4);
    rst_n = 1;
    drive(1, 32'h1000, 8'h00, 1);  // R2 width limit
    drive(1, 32'h1018, 8'h00, 2);  // R2 line end, two words
    drive(1, 32'h101C, 8'h00, 3);  // R2 last word only
    drive(0, 32'h5550, 8'hFF, 4);  // R8 idle
    drive(1, 32'h2004, 8'h04, 5);  // R3 taken in slot 1
    drive(1, 32'h2008, 8'h04, 6);  // R3 taken in slot 0
    drive(1, 32'h3000, 8'h80, 7);  // R3 taken flag beyond group ignored
    drive(0, 32'h0, 8'h00, 8);     // R8 idle
    drive(0, 32'h4, 8'h01, 9);
    for (int i = 0; i < 40; i++)
      drive(1'($urandom_range(0, 3) != 0), {$urandom_range(0, 255), 3'($urandom_range(0, 7)), 2'b00},
            8'($urandom_range(0, 255)) & 8'($urandom_range(0, 255)), 10 + i);
    drive(0, 32'h0, 8'h00, 99);
    drive(0, 32'h0, 8'h00, 100);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule